// File: doc/BRIEF.md
# DMA Indirect-Address Transfer Sequencer

This block is a single-channel DMA engine for a chip's internal bus. It moves data in dual-address mode, with the source reached through one level of indirection. The programmed pointer does not address the data. It addresses a table in memory, and each table entry holds the address of the data. For every transfer the engine reads the upper and lower halves of the stored address, leaving one idle bus cycle after each half. It then reads the data from the assembled address and writes that data to the destination.

Software-side logic loads the configuration inputs and pulses `start`. The engine latches the configuration and runs the programmed number of transfers. It then raises `done` and goes back to idle. The source read and the destination write can each be stretched to two bus cycles, so that slower regions can be served. The fetched address is kept in a private scratch register, and the pointer and destination registers only ever advance by their fixed steps.

Top module: `dma_indirect_seq`

## Requirements
- R1: While reset is active, and after it is released with no start, `bus_rd`, `bus_wr` and `done` are all low.
- R2: A `start` pulse seen in idle latches every `cfg_*` input and clears `done`. In the next cycle the engine reads the upper half of the indirect address at the pointer, with `bus_size` = 1 (halfword).
- R3: Each indirect-half read is followed by exactly one cycle with no strobe. The lower half is read at pointer + 2, also with size code 1. The data source address is {upper half, lower half}, taken from `bus_rdata[15:0]` of each fetch.
- R4: After the second idle cycle the engine reads at the assembled address with the latched size code (0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 treated as 2). `bus_rd` stays high 1 cycle, or 2 cycles when `cfg_src_two` was set. The data is taken in the last read cycle.
- R5: The write follows the read directly. It goes to the destination address with the same size code, and `bus_wdata` equals the captured read word. `bus_wr` stays high 1 cycle, or 2 cycles when `cfg_dst_two` was set, and the address holds steady throughout.
- R6: After each write the destination advances by 1, 2 or 4 bytes (from the size code) when `cfg_dst_inc` was set, and stays put otherwise.
- R7: The count drops by one per completed write. The cycle after the last write, the engine is idle with `done` high. `done` stays high until the next accepted start and is low while a sequence runs. A start with count 0 raises `done` the next cycle and makes no bus access.
- R8: The fetched address never replaces the pointer. The next transfer's fetch starts at the previous pointer + 4.
- R9: A `start` pulse that arrives while a sequence is active is ignored. This includes a pulse in the final write cycle.
- R10: `bus_rd` and `bus_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle start strobe |
| cfg_ptr | input | ADDR_W | Address of the first indirect-address table entry |
| cfg_dst | input | ADDR_W | First destination address |
| cfg_count | input | CNT_W | Number of transfers |
| cfg_size | input | 2 | Transfer size code |
| cfg_dst_inc | input | 1 | Advance the destination after each write |
| cfg_src_two | input | 1 | Source read lasts two cycles |
| cfg_dst_two | input | 1 | Destination write lasts two cycles |
| bus_addr | output | ADDR_W | Bus address |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_size | output | 2 | Access-length hint |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data, valid in the same cycle as the read strobe |
| done | output | 1 | Sequence finished |

## Verification
The risky overlap is a new `start` arriving in the very cycle the last write completes, while the engine is deciding to raise `done` and return to idle. The bench watches its reference model for the final write cycle and pulses `start` there with a fresh non-zero count. It expects the pulse to be dropped, `done` to rise the next cycle and the bus to stay quiet. A start issued one cycle later must be accepted. A second overlap is the pointer update at the end of a write landing on the same edge as the next transfer's first fetch. This is judged by the fetch address on the following cycle.

// File: rtl/dmai_pkg.sv
package dmai_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FHI,
        ST_GAP_HI,
        ST_FLO,
        ST_GAP_LO,
        ST_RD,
        ST_WR
    } dmai_state_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

endpackage

// File: rtl/dmai_strobe_timer.sv
// Stretches a bus strobe to one or two cycles and flags its final cycle.
module dmai_strobe_timer (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic two_cycle,
    output logic last
);
    logic held_d, held_q;

    always_comb begin
        last   = active & (~two_cycle | held_q);
        held_d = active & ~last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) held_q <= 1'b0;
        else        held_q <= held_d;
    end
endmodule

// File: rtl/dmai_ind_latch.sv
// Scratch register assembling the fetched source address from two halves.
module dmai_ind_latch #(
    parameter int HALF_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          cap,      // bit 1: upper half, bit 0: lower half
    input  logic [HALF_W-1:0]   din,
    output logic [2*HALF_W-1:0] addr
);
    for (genvar h = 0; h < 2; h++) begin : g_half
        logic [HALF_W-1:0] half_d, half_q;

        always_comb half_d = cap[h] ? din : half_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) half_q <= '0;
            else        half_q <= half_d;
        end

        assign addr[h*HALF_W +: HALF_W] = half_q;
    end
endmodule

// File: rtl/dmai_step_calc.sv
// Address arithmetic: lower-half fetch address, pointer and destination steps.
module dmai_step_calc
    import dmai_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int PTR_STEP   = 4,
    parameter int HALF_BYTES = 2
) (
    input  logic [ADDR_W-1:0] ptr,
    input  logic [ADDR_W-1:0] dst,
    input  logic [1:0]        size,
    input  logic              inc,
    output logic [ADDR_W-1:0] lo_addr,
    output logic [ADDR_W-1:0] ptr_next,
    output logic [ADDR_W-1:0] dst_next
);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(PTR_STEP);
    localparam logic [ADDR_W-1:0] LO_OFS = ADDR_W'(HALF_BYTES);

    logic [ADDR_W-1:0] bytes;

    always_comb begin
        case (size)
            SZ_BYTE: bytes = ADDR_W'(1);
            SZ_HALF: bytes = ADDR_W'(2);
            default: bytes = ADDR_W'(4);
        endcase
        lo_addr  = ptr + LO_OFS;
        ptr_next = ptr + STEP_V;
        dst_next = inc ? dst + bytes : dst;
    end
endmodule

// File: rtl/dma_indirect_seq.sv
module dma_indirect_seq
    import dmai_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int CNT_W    = 16,
    parameter int PTR_STEP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] cfg_ptr,
    input  logic [ADDR_W-1:0] cfg_dst,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic [1:0]        cfg_size,
    input  logic              cfg_dst_inc,
    input  logic              cfg_src_two,
    input  logic              cfg_dst_two,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [1:0]        bus_size,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              done
);
    localparam int HALF_W     = ADDR_W / 2;
    localparam int HALF_BYTES = HALF_W / 8;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        dmai_state_e       state;
        logic [ADDR_W-1:0] ptr;
        logic [ADDR_W-1:0] dst;
        logic [CNT_W-1:0]  cnt;
        logic [1:0]        size;
        logic              inc;
        logic              src_two;
        logic              dst_two;
        logic [DATA_W-1:0] data;
        logic              done;
    } seq_regs_t;

    seq_regs_t d, q;

    logic [1:0]        cap;
    logic [ADDR_W-1:0] ind_addr;
    logic [ADDR_W-1:0] lo_addr, ptr_next, dst_next;
    logic [1:0]        tmr_act, tmr_two, tmr_last;

    // Signals observed by the bound checker
    dmai_state_e       cur_state;
    logic [ADDR_W-1:0] cur_ptr;
    logic [1:0]        cur_size;
    logic              cur_dst_two;

    dmai_ind_latch #(.HALF_W(HALF_W)) u_ind (
        .clk  (clk),
        .rst_n(rst_n),
        .cap  (cap),
        .din  (bus_rdata[HALF_W-1:0]),
        .addr (ind_addr)
    );

    dmai_step_calc #(
        .ADDR_W    (ADDR_W),
        .PTR_STEP  (PTR_STEP),
        .HALF_BYTES(HALF_BYTES)
    ) u_step (
        .ptr     (q.ptr),
        .dst     (q.dst),
        .size    (q.size),
        .inc     (q.inc),
        .lo_addr (lo_addr),
        .ptr_next(ptr_next),
        .dst_next(dst_next)
    );

    // Index 0 stretches the source read, index 1 the destination write
    assign tmr_two = {q.dst_two, q.src_two};
    for (genvar t = 0; t < 2; t++) begin : g_tmr
        dmai_strobe_timer u_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .active   (tmr_act[t]),
            .two_cycle(tmr_two[t]),
            .last     (tmr_last[t])
        );
    end

    always_comb begin
        d         = q;
        bus_addr  = '0;
        bus_rd    = 1'b0;
        bus_wr    = 1'b0;
        bus_size  = SZ_BYTE;
        bus_wdata = '0;
        cap       = 2'b00;
        tmr_act   = 2'b00;

        case (q.state)
            ST_IDLE: begin
                if (start) begin
                    d.ptr     = cfg_ptr;
                    d.dst     = cfg_dst;
                    d.cnt     = cfg_count;
                    d.size    = (cfg_size == 2'd3) ? SZ_WORD : cfg_size;
                    d.inc     = cfg_dst_inc;
                    d.src_two = cfg_src_two;
                    d.dst_two = cfg_dst_two;
                    if (cfg_count == '0) begin
                        d.done = 1'b1;
                    end else begin
                        d.done  = 1'b0;
                        d.state = ST_FHI;
                    end
                end
            end
            ST_FHI: begin
                bus_rd   = 1'b1;
                bus_addr = q.ptr;
                bus_size = SZ_HALF;
                cap      = 2'b10;
                d.state  = ST_GAP_HI;
            end
            ST_GAP_HI: d.state = ST_FLO;
            ST_FLO: begin
                bus_rd   = 1'b1;
                bus_addr = lo_addr;
                bus_size = SZ_HALF;
                cap      = 2'b01;
                d.state  = ST_GAP_LO;
            end
            ST_GAP_LO: d.state = ST_RD;
            ST_RD: begin
                bus_rd     = 1'b1;
                bus_addr   = ind_addr;
                bus_size   = q.size;
                tmr_act[0] = 1'b1;
                if (tmr_last[0]) begin
                    d.data  = bus_rdata;
                    d.state = ST_WR;
                end
            end
            ST_WR: begin
                bus_wr     = 1'b1;
                bus_addr   = q.dst;
                bus_size   = q.size;
                bus_wdata  = q.data;
                tmr_act[1] = 1'b1;
                if (tmr_last[1]) begin
                    d.ptr = ptr_next;
                    d.dst = dst_next;
                    d.cnt = q.cnt - CNT_ONE;
                    if (q.cnt == CNT_ONE) begin
                        d.state = ST_IDLE;
                        d.done  = 1'b1;
                    end else begin
                        d.state = ST_FHI;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign done        = q.done;
    assign cur_state   = q.state;
    assign cur_ptr     = q.ptr;
    assign cur_size    = q.size;
    assign cur_dst_two = q.dst_two;
endmodule

// File: rtl/dmai_seq_chk.sv
module dmai_seq_chk
    import dmai_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              done,
    input dmai_state_e       st,
    input logic [ADDR_W-1:0] ptr,
    input logic [1:0]        size,
    input logic              dst_two
);
    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    // R3
    fetch_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FHI || st == ST_FLO) |=> (!bus_rd && !bus_wr));

    // R5
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_wr) && dst_two) |=> (bus_wr && $stable(bus_addr)));

    // R8
    ptr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && st != ST_WR) |=> $stable(ptr));

    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && start) |=> $stable(size));

    // R7
    done_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |-> !done);
endmodule

bind dma_indirect_seq dmai_seq_chk #(.ADDR_W(ADDR_W)) u_seq_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .bus_rd  (bus_rd),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .done    (done),
    .st      (cur_state),
    .ptr     (cur_ptr),
    .size    (cur_size),
    .dst_two (cur_dst_two)
);

// File: tb/test_dma_indirect_seq.sv
module test_dma_indirect_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] cfg_ptr = '0, cfg_dst = '0;
    logic [15:0] cfg_count = '0;
    logic [1:0]  cfg_size = '0;
    logic        cfg_dst_inc = 1'b0, cfg_src_two = 1'b0, cfg_dst_two = 1'b0;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;
    logic        bus_rd, bus_wr, done;
    logic [1:0]  bus_size;

    always #10 clk = ~clk;

    dma_indirect_seq i_dma_indirect_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_ptr(cfg_ptr), .cfg_dst(cfg_dst), .cfg_count(cfg_count),
        .cfg_size(cfg_size), .cfg_dst_inc(cfg_dst_inc),
        .cfg_src_two(cfg_src_two), .cfg_dst_two(cfg_dst_two),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .done(done)
    );

    // Bench memory: low region holds indirect-address halves, the rest holds data
    function automatic logic [31:0] mem_rd(logic [31:0] a);
        logic [15:0] h;
        if (a[31:16] == 16'h0) begin
            if (a[1]) h = {a[13:2], 4'b0011} ^ 16'h0300;
            else      h = 16'h0001 + {12'h0, a[5:2]};
            return {16'h0, h};
        end
        return {~a[15:0], a[15:0] ^ a[31:16]};
    endfunction

    assign bus_rdata = bus_rd ? mem_rd(bus_addr) : 32'h0;

    typedef struct {
        bit          active;
        bit          rd;
        bit          wr;
        logic [31:0] addr;
        logic [1:0]  size;
        logic [31:0] wdata;
        string       tag;
    } cyc_t;

    cyc_t expq[$];
    cyc_t cur;
    bit   ref_done;
    bit   was_act;
    bit   fin = 1'b0;
    int   n_chk = 0, n_fail = 0;

    function automatic cyc_t mk(bit act, bit rd, bit wr, logic [31:0] a,
                                logic [1:0] sz, logic [31:0] wd, string tag);
        cyc_t c;
        c.active = act; c.rd = rd; c.wr = wr; c.addr = a;
        c.size = sz; c.wdata = wd; c.tag = tag;
        return c;
    endfunction

    task automatic chk(bit ok, string tag, string act, string exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %s expected %s", tag, act, exp);
        end
    endtask

    task automatic build();
        logic [31:0] p, dd, src, hi, lo, wd, nbytes;
        logic [1:0]  sz;
        p  = cfg_ptr;
        dd = cfg_dst;
        sz = (cfg_size == 2'd3) ? 2'd2 : cfg_size;
        nbytes = (sz == 2'd0) ? 32'd1 : (sz == 2'd1) ? 32'd2 : 32'd4;
        for (int i = 0; i < int'(cfg_count); i++) begin
            hi  = mem_rd(p);
            lo  = mem_rd(p + 32'd2);
            src = {hi[15:0], lo[15:0]};
            wd  = mem_rd(src);
            expq.push_back(mk(1, 1, 0, p, 2'd1, '0, (i == 0) ? "R2" : "R8"));
            expq.push_back(mk(1, 0, 0, '0, '0, '0, "R3"));
            expq.push_back(mk(1, 1, 0, p + 32'd2, 2'd1, '0, "R3"));
            expq.push_back(mk(1, 0, 0, '0, '0, '0, "R3"));
            for (int k = 0; k < (cfg_src_two ? 2 : 1); k++)
                expq.push_back(mk(1, 1, 0, src, sz, '0, "R4"));
            for (int k = 0; k < (cfg_dst_two ? 2 : 1); k++)
                expq.push_back(mk(1, 0, 1, dd, sz, wd, (i == 0) ? "R5" : "R6"));
            p = p + 32'd4;
            if (cfg_dst_inc) dd = dd + nbytes;
        end
    endtask

    // Reference model: advances one cycle per rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            expq.delete();
            cur = mk(0, 0, 0, '0, '0, '0, "R1");
            ref_done = 1'b0;
        end else begin
            was_act = cur.active;
            if (!was_act && start) begin
                ref_done = 1'b0;
                build();
                if (cfg_count == 16'd0) ref_done = 1'b1;
            end
            if (expq.size() > 0) begin
                cur = expq.pop_front();
            end else begin
                if (was_act) ref_done = 1'b1;
                cur = mk(0, 0, 0, '0, '0, '0, "R7");
            end
        end
    end

    // Compare against the model away from the active edge
    always @(negedge clk) begin
        if (rst_n && !fin) begin
            bit ok;
            ok = (bus_rd == cur.rd) && (bus_wr == cur.wr) &&
                 (!(cur.rd || cur.wr) || (bus_addr == cur.addr && bus_size == cur.size)) &&
                 (!cur.wr || bus_wdata == cur.wdata);
            chk(ok, cur.tag,
                $sformatf("rd=%b wr=%b addr=%h size=%0d wdata=%h", bus_rd, bus_wr, bus_addr, bus_size, bus_wdata),
                $sformatf("rd=%b wr=%b addr=%h size=%0d wdata=%h", cur.rd, cur.wr, cur.addr, cur.size, cur.wdata));
            chk(done == (cur.active ? 1'b0 : ref_done), "R7",
                $sformatf("done=%b", done), $sformatf("done=%b", cur.active ? 1'b0 : ref_done));
            chk(!(bus_rd && bus_wr), "R10",
                $sformatf("rd=%b wr=%b", bus_rd, bus_wr), "not both");
        end
    end

    task automatic launch(logic [31:0] p, logic [31:0] dd, logic [15:0] n,
                          logic [1:0] sz, bit inc, bit s2, bit d2);
        @(negedge clk);
        cfg_ptr = p; cfg_dst = dd; cfg_count = n; cfg_size = sz;
        cfg_dst_inc = inc; cfg_src_two = s2; cfg_dst_two = d2;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        while (cur.active || expq.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        fin = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        // R1: idle outputs during reset
        chk(!bus_rd && !bus_wr && !done, "R1",
            $sformatf("rd=%b wr=%b done=%b", bus_rd, bus_wr, done), "all low");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!bus_rd && !bus_wr && !done, "R1",
            $sformatf("rd=%b wr=%b done=%b", bus_rd, bus_wr, done), "all low");

        // Byte transfers, 1-cycle source, 2-cycle destination, incrementing (R2..R6, R8)
        launch(32'h0000_0100, 32'h2000_0000, 16'd3, 2'd0, 1'b1, 1'b0, 1'b1);
        wait_idle();

        // Word transfers, 2-cycle source, fixed destination, with a start mid-run (R9)
        launch(32'h0000_0200, 32'h3000_0010, 16'd3, 2'd2, 1'b0, 1'b1, 1'b0);
        repeat (6) @(negedge clk);
        cfg_count = 16'd7; cfg_size = 2'd0; cfg_ptr = 32'h0000_0400;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle();

        // Halfword, both two-cycle; start in the final write cycle must be dropped (R9)
        launch(32'h0000_0300, 32'h4000_0002, 16'd2, 2'd1, 1'b1, 1'b1, 1'b1);
        while (!(cur.active && cur.wr && expq.size() == 0)) @(negedge clk);
        cfg_count = 16'd5; cfg_ptr = 32'h0000_0500;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done && !bus_rd && !bus_wr, "R9",
            $sformatf("done=%b rd=%b wr=%b", done, bus_rd, bus_wr), "done=1 rd=0 wr=0");
        repeat (2) @(negedge clk);
        chk(done && !bus_rd, "R9", $sformatf("done=%b rd=%b", done, bus_rd), "done=1 rd=0");

        // Start right after done; size code 3 behaves as 32 bits (R4)
        launch(32'h0000_0600, 32'h5000_0000, 16'd2, 2'd3, 1'b1, 1'b0, 1'b0);
        wait_idle();

        // Count of zero: done without any bus access (R7)
        launch(32'h0000_0700, 32'h6000_0000, 16'd0, 2'd2, 1'b1, 1'b0, 1'b0);
        chk(done && !bus_rd && !bus_wr, "R7",
            $sformatf("done=%b rd=%b wr=%b", done, bus_rd, bus_wr), "done=1 no access");
        repeat (3) @(negedge clk);

        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!fin) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual running expected finished");
            summary();
        end
    end
endmodule